// File: doc/BRIEF.md
# AEAD Stream Phase Sequencer

This block is the control and framing layer of a 128-bit authenticated-encryption datapath. Each message starts with a setup handshake. The handshake carries a 256-bit key, a 96-bit nonce and two mode bits. After the handshake the block walks through two phases on one shared input bus: associated data first, then payload. Each accepted beat is forwarded on one shared output bus. Associated-data beats and payload beats have their own valid and last flags. The output byte enable copies the input byte enable, and bytes that are not enabled are driven to zero.

In the cipher modes (encrypt or decrypt), every payload word is XORed with a keystream word. The keystream word comes from a request/grant port. While that port withholds its grant, payload input is stalled. When the payload is finished, the block asks a MAC-result port for the tag and emits it as a single tag beat. In bypass mode, data passes through unchanged and no tag beat is emitted. The captured key, nonce and decrypt bit are presented to the external keystream and MAC engines. A phase with no data is framed by one beat that carries the phase's last flag and an all-zero byte enable.

Top module: `aead_phase_seq`

## Requirements
- R1: While `rst_n` is low (synchronous), the block goes idle. `cfg_ready` is 1. `ad_ready`, `pl_ready`, `ad_out_valid`, `pl_out_valid`, `tag_valid` and `proto_err` are 0.
- R2: A setup handshake happens on a cycle where `cfg_valid` and `cfg_ready` are both 1. On that cycle the block captures `cfg_key`, `cfg_nonce`, `cfg_decrypt` and `cfg_bypass`. From the next cycle, `run_key` and `run_nonce` show the captured key and nonce. `cfg_ready` stays 0 until the message completes.
- R3: After setup, `ad_ready` is 1 and `pl_ready` is 0. This holds until a beat with `in_valid` and `ad_last` is accepted. Each accepted associated-data beat produces `ad_out_valid`=1 on the next cycle, with `ad_out_last` equal to that beat's `ad_last`. At most one of `ad_out_valid`, `pl_out_valid` and `tag_valid` is 1 in any cycle.
- R4: In the payload phase of the cipher modes (`cfg_bypass`=0, with `cfg_decrypt` either 0 or 1), `ks_req` is 1 and `pl_ready` equals `ks_grant`. On the cycle after an accepted beat, `pl_out_valid` is 1 and `out_data` is the input word XORed with `ks_word`, masked. `pl_out_last` copies `pl_last`.
- R5: In bypass mode (`cfg_bypass`=1, which overrides `cfg_decrypt`), `ks_req` is 0 and `pl_ready` is 1 throughout the payload phase. Payload words pass through unchanged apart from masking, and no tag beat appears. `cfg_ready` is 0 on the cycle with `pl_out_valid`=1 and `pl_out_last`=1, and it is 1 on the cycle after.
- R6: For every output beat, `out_be` equals the input byte enable. Byte i of `out_data` (bits 8i+7..8i) equals the corresponding input byte when `out_be[i]`=1, and 0 otherwise.
- R7: A phase may be empty. It is then signalled by one valid beat that has the phase's last flag set and `in_be`=0. That beat advances the phase and produces an output beat with `out_be`=0 and `out_data`=0.
- R8: In the cipher modes, `mac_req` is 1 after the last payload beat is accepted. On the cycle after a cycle where `mac_req` and `mac_valid` are both 1, `tag_valid` is 1 and `tag_out` equals the `mac_tag` that was presented. `cfg_ready` is 1 on the cycle after `tag_valid`.
- R9: An accepted beat whose `in_be` is not a run of ones starting at bit 0 sets `proto_err` from the next cycle. The test for this is (be & (be+1)) != 0. `proto_err` stays set until the next setup handshake clears it.
- R10: No output valid flag rises for an input cycle where the ready flag of the current phase is 0. This covers `in_valid` asserted while idle and payload beats that are stalled by a missing grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ready | output | 1 | Block can accept a new message setup |
| cfg_valid | input | 1 | Setup fields are valid |
| cfg_decrypt | input | 1 | 1 selects decryption (ignored in bypass) |
| cfg_bypass | input | 1 | 1 passes data through with no tag |
| cfg_key | input | 256 | Message key |
| cfg_nonce | input | 96 | Message nonce |
| run_key | output | 256 | Captured key for the keystream/MAC engines |
| run_nonce | output | 96 | Captured nonce for the keystream engine |
| run_decrypt | output | 1 | Captured decrypt bit |
| ad_ready | output | 1 | Associated-data phase is accepting beats |
| pl_ready | output | 1 | Payload phase is accepting beats |
| in_valid | input | 1 | Input beat is valid |
| ad_last | input | 1 | Final associated-data beat |
| pl_last | input | 1 | Final payload beat |
| in_be | input | 16 | Input byte enable, contiguous from bit 0 |
| in_data | input | 128 | Shared input word |
| ks_req | output | 1 | Keystream word wanted |
| ks_grant | input | 1 | Keystream word available |
| ks_word | input | 128 | Keystream word |
| mac_req | output | 1 | Tag wanted |
| mac_valid | input | 1 | Tag available |
| mac_tag | input | 128 | Tag value |
| ad_out_valid | output | 1 | Output word is associated data |
| ad_out_last | output | 1 | Final associated-data output beat |
| pl_out_valid | output | 1 | Output word is payload |
| pl_out_last | output | 1 | Final payload output beat |
| out_be | output | 16 | Output byte enable |
| out_data | output | 128 | Shared output word |
| tag_valid | output | 1 | Tag beat valid |
| tag_out | output | 128 | Tag value |
| proto_err | output | 1 | Sticky malformed byte-enable flag |

## Verification
The hardest situation to reach is an encrypted message in which the payload beat is stalled by a withheld keystream grant while its input is already valid. The output must not advance, and the keystream index must not move. Once the grant returns, the XOR must use the word of that exact index. To reach this, the stimulus drops `ks_grant` at random on about one cycle in three while beats are held valid. The bench counts its own keystream index. Empty phases in every mode, a delayed MAC result and a malformed byte enable followed by a fresh setup are driven as directed cases. These sit among random message lengths and random partial last beats.

// File: rtl/aead_seq_pkg.sv
package aead_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_AD,
        ST_PL,
        ST_TAG,
        ST_WRAP
    } seq_state_e;
endpackage

// File: rtl/aead_be_unit.sv
module aead_be_unit #(
    parameter int DATA_W = 128,
    localparam int BE_W  = DATA_W / 8
) (
    input  logic [DATA_W-1:0] word_i,
    input  logic [BE_W-1:0]   be_i,
    output logic [DATA_W-1:0] masked_o,
    output logic              contig_o
);
    logic [BE_W-1:0] be_inc;

    // Clear every byte lane whose enable is low
    for (genvar g = 0; g < BE_W; g++) begin : g_lane
        assign masked_o[8*g +: 8] = be_i[g] ? word_i[8*g +: 8] : 8'h00;
    end

    // A run of ones from bit 0 has no overlap with its successor
    assign be_inc   = be_i + {{(BE_W-1){1'b0}}, 1'b1};
    assign contig_o = ((be_i & be_inc) == '0);
endmodule

// File: rtl/aead_seq_ctrl.sv
module aead_seq_ctrl
    import aead_seq_pkg::*;
#(
    parameter int KEY_W   = 256,
    parameter int NONCE_W = 96
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_valid,
    input  logic               cfg_decrypt,
    input  logic               cfg_bypass,
    input  logic [KEY_W-1:0]   cfg_key,
    input  logic [NONCE_W-1:0] cfg_nonce,
    input  logic               in_valid,
    input  logic               ad_last,
    input  logic               pl_last,
    input  logic               be_contig,
    input  logic               ks_grant,
    input  logic               mac_valid,
    output logic               cfg_ready,
    output logic               ad_ready,
    output logic               pl_ready,
    output logic               ks_req,
    output logic               mac_req,
    output logic               ad_take,
    output logic               pl_take,
    output logic               tag_take,
    output logic [KEY_W-1:0]   run_key,
    output logic [NONCE_W-1:0] run_nonce,
    output logic               run_decrypt,
    output logic               proto_err
);
    typedef struct packed {
        seq_state_e         state;
        logic               bypass;
        logic               decrypt;
        logic [KEY_W-1:0]   key;
        logic [NONCE_W-1:0] nonce;
        logic               err;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;

    always_comb begin
        cfg_ready = (ctl_q.state == ST_IDLE);
        ad_ready  = (ctl_q.state == ST_AD);
        pl_ready  = (ctl_q.state == ST_PL) && (ctl_q.bypass || ks_grant);
        ks_req    = (ctl_q.state == ST_PL) && !ctl_q.bypass;
        mac_req   = (ctl_q.state == ST_TAG);
        ad_take   = ad_ready && in_valid;
        pl_take   = pl_ready && in_valid;
        tag_take  = mac_req && mac_valid;

        ctl_d = ctl_q;
        if ((ad_take || pl_take) && !be_contig) begin
            ctl_d.err = 1'b1;
        end
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (cfg_valid) begin
                    ctl_d.state   = ST_AD;
                    ctl_d.bypass  = cfg_bypass;
                    ctl_d.decrypt = cfg_decrypt;
                    ctl_d.key     = cfg_key;
                    ctl_d.nonce   = cfg_nonce;
                    ctl_d.err     = 1'b0;
                end
            end
            ST_AD: begin
                if (ad_take && ad_last) begin
                    ctl_d.state = ST_PL;
                end
            end
            ST_PL: begin
                if (pl_take && pl_last) begin
                    ctl_d.state = ctl_q.bypass ? ST_WRAP : ST_TAG;
                end
            end
            ST_TAG: begin
                if (tag_take) begin
                    ctl_d.state = ST_WRAP;
                end
            end
            default: begin
                ctl_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_IDLE, bypass: 1'b0, decrypt: 1'b0,
                       key: '0, nonce: '0, err: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign run_key     = ctl_q.key;
    assign run_nonce   = ctl_q.nonce;
    assign run_decrypt = ctl_q.decrypt;
    assign proto_err   = ctl_q.err;

    AST_SETUP_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && cfg_ready) |=> (!cfg_ready && ad_ready && !proto_err)); // R2

    AST_AD_BEFORE_PL: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctl_q.state == ST_PL) && ($past(ctl_q.state) != ST_PL))
            |-> $past(ad_take && ad_last)); // R3

    AST_BYPASS_NO_MAC: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.bypass |-> !mac_req); // R5

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (proto_err && !(cfg_valid && cfg_ready)) |=> proto_err); // R9
endmodule

// File: rtl/aead_out_stage.sv
module aead_out_stage #(
    parameter int DATA_W = 128,
    localparam int BE_W  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ad_take,
    input  logic              pl_take,
    input  logic              ad_last,
    input  logic              pl_last,
    input  logic              tag_take,
    input  logic [BE_W-1:0]   be_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [DATA_W-1:0] tag_i,
    output logic              ad_out_valid,
    output logic              ad_out_last,
    output logic              pl_out_valid,
    output logic              pl_out_last,
    output logic [BE_W-1:0]   out_be,
    output logic [DATA_W-1:0] out_data,
    output logic              tag_valid,
    output logic [DATA_W-1:0] tag_out
);
    typedef struct packed {
        logic              ad_v;
        logic              ad_l;
        logic              pl_v;
        logic              pl_l;
        logic [BE_W-1:0]   be;
        logic [DATA_W-1:0] data;
        logic              tag_v;
        logic [DATA_W-1:0] tag;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d       = out_q;
        out_d.ad_v  = ad_take;
        out_d.ad_l  = ad_take && ad_last;
        out_d.pl_v  = pl_take;
        out_d.pl_l  = pl_take && pl_last;
        out_d.tag_v = tag_take;
        if (ad_take || pl_take) begin
            out_d.be   = be_i;
            out_d.data = data_i;
        end
        if (tag_take) begin
            out_d.tag = tag_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign ad_out_valid = out_q.ad_v;
    assign ad_out_last  = out_q.ad_l;
    assign pl_out_valid = out_q.pl_v;
    assign pl_out_last  = out_q.pl_l;
    assign out_be       = out_q.be;
    assign out_data     = out_q.data;
    assign tag_valid    = out_q.tag_v;
    assign tag_out      = out_q.tag;

    logic [DATA_W-1:0] lane_mask;
    for (genvar g = 0; g < BE_W; g++) begin : g_chk
        assign lane_mask[8*g +: 8] = {8{out_q.be[g]}};
    end

    AST_ONE_BEAT_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ad_out_valid, pl_out_valid, tag_valid})); // R3

    AST_DEAD_BYTES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ad_out_valid || pl_out_valid) |-> ((out_data & ~lane_mask) == '0)); // R6
endmodule

// File: rtl/aead_phase_seq.sv
module aead_phase_seq #(
    parameter int DATA_W  = 128,
    parameter int KEY_W   = 256,
    parameter int NONCE_W = 96,
    localparam int BE_W   = DATA_W / 8
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic               cfg_ready,
    input  logic               cfg_valid,
    input  logic               cfg_decrypt,
    input  logic               cfg_bypass,
    input  logic [KEY_W-1:0]   cfg_key,
    input  logic [NONCE_W-1:0] cfg_nonce,
    output logic [KEY_W-1:0]   run_key,
    output logic [NONCE_W-1:0] run_nonce,
    output logic               run_decrypt,
    output logic               ad_ready,
    output logic               pl_ready,
    input  logic               in_valid,
    input  logic               ad_last,
    input  logic               pl_last,
    input  logic [BE_W-1:0]    in_be,
    input  logic [DATA_W-1:0]  in_data,
    output logic               ks_req,
    input  logic               ks_grant,
    input  logic [DATA_W-1:0]  ks_word,
    output logic               mac_req,
    input  logic               mac_valid,
    input  logic [DATA_W-1:0]  mac_tag,
    output logic               ad_out_valid,
    output logic               ad_out_last,
    output logic               pl_out_valid,
    output logic               pl_out_last,
    output logic [BE_W-1:0]    out_be,
    output logic [DATA_W-1:0]  out_data,
    output logic               tag_valid,
    output logic [DATA_W-1:0]  tag_out,
    output logic               proto_err
);
    logic              ad_take, pl_take, tag_take, be_contig;
    logic [DATA_W-1:0] word_sel, word_masked;

    // Keystream applies only while the payload phase runs in a cipher mode
    assign word_sel = ks_req ? (in_data ^ ks_word) : in_data;

    aead_be_unit #(.DATA_W(DATA_W)) i_be_unit (
        .word_i   (word_sel),
        .be_i     (in_be),
        .masked_o (word_masked),
        .contig_o (be_contig)
    );

    aead_seq_ctrl #(.KEY_W(KEY_W), .NONCE_W(NONCE_W)) i_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_valid   (cfg_valid),
        .cfg_decrypt (cfg_decrypt),
        .cfg_bypass  (cfg_bypass),
        .cfg_key     (cfg_key),
        .cfg_nonce   (cfg_nonce),
        .in_valid    (in_valid),
        .ad_last     (ad_last),
        .pl_last     (pl_last),
        .be_contig   (be_contig),
        .ks_grant    (ks_grant),
        .mac_valid   (mac_valid),
        .cfg_ready   (cfg_ready),
        .ad_ready    (ad_ready),
        .pl_ready    (pl_ready),
        .ks_req      (ks_req),
        .mac_req     (mac_req),
        .ad_take     (ad_take),
        .pl_take     (pl_take),
        .tag_take    (tag_take),
        .run_key     (run_key),
        .run_nonce   (run_nonce),
        .run_decrypt (run_decrypt),
        .proto_err   (proto_err)
    );

    aead_out_stage #(.DATA_W(DATA_W)) i_out (
        .clk          (clk),
        .rst_n        (rst_n),
        .ad_take      (ad_take),
        .pl_take      (pl_take),
        .ad_last      (ad_last),
        .pl_last      (pl_last),
        .tag_take     (tag_take),
        .be_i         (in_be),
        .data_i       (word_masked),
        .tag_i        (mac_tag),
        .ad_out_valid (ad_out_valid),
        .ad_out_last  (ad_out_last),
        .pl_out_valid (pl_out_valid),
        .pl_out_last  (pl_out_last),
        .out_be       (out_be),
        .out_data     (out_data),
        .tag_valid    (tag_valid),
        .tag_out      (tag_out)
    );

    AST_TAG_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        tag_valid |=> cfg_ready); // R8

    AST_NO_BEAT_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_ready |=> !(ad_out_valid || pl_out_valid)); // R10
endmodule

// File: tb/test_aead_phase_seq.sv
module test_aead_phase_seq;
    localparam int DW = 128;
    localparam int KW = 256;
    localparam int NW = 96;
    localparam int BW = DW / 8;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst_n, cfg_ready, cfg_valid, cfg_decrypt, cfg_bypass;
    logic [KW-1:0] cfg_key, run_key;
    logic [NW-1:0] cfg_nonce, run_nonce;
    logic          run_decrypt, ad_ready, pl_ready, in_valid, ad_last, pl_last;
    logic [BW-1:0] in_be, out_be;
    logic [DW-1:0] in_data, ks_word, mac_tag, out_data, tag_out;
    logic          ks_req, ks_grant, mac_req, mac_valid;
    logic          ad_out_valid, ad_out_last, pl_out_valid, pl_out_last;
    logic          tag_valid, proto_err;

    aead_phase_seq i_aead_phase_seq (.*);

    int          checks = 0;
    int          errors = 0;
    bit          err_model = 1'b0;
    bit          mode_byp = 1'b0;
    int unsigned ks_cnt = 0;

    task automatic chk(input bit ok, input string req, input logic [255:0] act,
                       input logic [255:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [BW-1:0] cmask(input int n);
        if (n >= BW) return '1;
        return BW'((1 << n) - 1);
    endfunction

    function automatic logic [DW-1:0] bmask(input logic [DW-1:0] d, input logic [BW-1:0] be);
        logic [DW-1:0] r = '0;
        for (int i = 0; i < BW; i++) if (be[i]) r[8*i +: 8] = d[8*i +: 8];
        return r;
    endfunction

    function automatic logic [DW-1:0] ks_fn(input int unsigned n);
        return {n * 32'h9E3779B9, n ^ 32'hA5A5F00F, ~n, n + 32'h01234567};
    endfunction

    function automatic bit contig(input logic [BW-1:0] be);
        return (be & (be + 1'b1)) == '0;
    endfunction

    function automatic logic [DW-1:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic setup(input bit dec, input bit byp);
        logic [KW-1:0] k = {rnd128(), rnd128()};
        logic [NW-1:0] n = {$urandom, $urandom, $urandom};
        @(negedge clk);
        cfg_valid = 1'b1; cfg_decrypt = dec; cfg_bypass = byp; cfg_key = k; cfg_nonce = n;
        #1;
        chk(cfg_ready == 1'b1, "R2 ready before setup", cfg_ready, 1);
        @(posedge clk);
        @(negedge clk);
        cfg_valid = 1'b0;
        cfg_key = '0; cfg_nonce = '0;
        mode_byp  = byp;
        err_model = 1'b0;
        chk(run_key == k, "R2 key captured", run_key, k);
        chk(run_nonce == n, "R2 nonce captured", run_nonce, n);
        chk(cfg_ready == 1'b0, "R2 busy after setup", cfg_ready, 0);
        chk(ad_ready == 1'b1, "R3 ad ready after setup", ad_ready, 1);
        chk(proto_err == 1'b0, "R9 error cleared by setup", proto_err, 0);
    endtask

    task automatic send(input bit pl, input logic [DW-1:0] d, input logic [BW-1:0] be,
                        input bit last);
        bit            acc = 1'b0;
        logic [DW-1:0] kw = '0;
        logic [DW-1:0] exp;
        while (!acc) begin
            @(negedge clk);
            chk(!ad_out_valid && !pl_out_valid, "R10 no output without accepted beat",
                {ad_out_valid, pl_out_valid}, 0);
            in_valid = 1'b1; in_data = d; in_be = be;
            ad_last = !pl && last; pl_last = pl && last;
            ks_grant = ($urandom % 3) != 0;
            kw = ks_fn(ks_cnt);
            ks_word = kw;
            #1;
            if (pl) begin
                if (mode_byp)
                    chk(pl_ready && !ks_req, "R5 bypass ignores keystream",
                        {pl_ready, ks_req}, 2'b10);
                else
                    chk(pl_ready == ks_grant && ks_req, "R4 payload waits for grant",
                        {pl_ready, ks_req}, {ks_grant, 1'b1});
                chk(!ad_ready, "R3 ad ready dropped in payload", ad_ready, 0);
                acc = pl_ready;
            end else begin
                chk(!pl_ready, "R3 no payload ready during ad", pl_ready, 0);
                acc = ad_ready;
            end
            @(posedge clk);
        end
        if (pl && !mode_byp) ks_cnt++;
        if (!contig(be)) err_model = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; ad_last = 1'b0; pl_last = 1'b0;
        exp = bmask((pl && !mode_byp) ? (d ^ kw) : d, be);
        if (pl)
            chk(pl_out_valid && pl_out_last == last && !ad_out_valid,
                mode_byp ? "R5 payload flags" : "R4 payload flags",
                {ad_out_valid, pl_out_valid, pl_out_last}, {2'b01, last});
        else
            chk(ad_out_valid && ad_out_last == last && !pl_out_valid, "R3 ad flags",
                {ad_out_valid, ad_out_last, pl_out_valid}, {1'b1, last, 1'b0});
        chk(out_be == be, "R6 byte enable copied", out_be, be);
        chk(out_data == exp, pl ? (mode_byp ? "R5 bypass data" : "R4 cipher data")
                                : "R6 masked ad data", out_data, exp);
        chk(proto_err == err_model, "R9 error flag", proto_err, err_model);
    endtask

    task automatic phase(input bit pl, input int n);
        if (n == 0) begin
            send(pl, rnd128(), '0, 1'b1);
            chk(out_be == '0 && out_data == '0, "R7 empty phase beat", {out_be, out_data}, 0);
        end else begin
            for (int i = 0; i < n; i++)
                send(pl, rnd128(), (i == n - 1) ? cmask(1 + $urandom % BW) : '1, i == n - 1);
        end
    endtask

    task automatic finish_msg();
        logic [DW-1:0] t;
        if (mode_byp) begin
            chk(!cfg_ready && !tag_valid, "R5 busy on last beat, no tag", {cfg_ready, tag_valid}, 0);
            @(negedge clk);
            chk(cfg_ready && !tag_valid, "R5 ready after last beat", {cfg_ready, tag_valid}, 2'b10);
        end else begin
            t = rnd128();
            repeat ($urandom % 3) begin
                @(negedge clk);
                chk(!tag_valid, "R8 no tag before mac result", tag_valid, 0);
            end
            mac_valid = 1'b1; mac_tag = t;
            #1;
            chk(mac_req == 1'b1, "R8 mac requested", mac_req, 1);
            @(posedge clk);
            @(negedge clk);
            mac_valid = 1'b0;
            chk(tag_valid && tag_out == t, "R8 tag beat", {tag_valid, tag_out}, {1'b1, t});
            chk(!cfg_ready && !pl_out_valid, "R8 busy during tag", {cfg_ready, pl_out_valid}, 0);
            @(negedge clk);
            chk(cfg_ready && !tag_valid, "R8 ready after tag", {cfg_ready, tag_valid}, 2'b10);
        end
    endtask

    task automatic msg(input bit dec, input bit byp, input int nad, input int npl);
        setup(dec, byp);
        phase(1'b0, nad);
        phase(1'b1, npl);
        finish_msg();
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; cfg_valid = 1'b0; cfg_decrypt = 1'b0; cfg_bypass = 1'b0;
        cfg_key = '0; cfg_nonce = '0; in_valid = 1'b0; ad_last = 1'b0; pl_last = 1'b0;
        in_be = '0; in_data = '0; ks_grant = 1'b0; ks_word = '0;
        mac_valid = 1'b0; mac_tag = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(cfg_ready && !ad_ready && !pl_ready, "R1 reset ready flags",
            {cfg_ready, ad_ready, pl_ready}, 3'b100);
        chk(!ad_out_valid && !pl_out_valid && !tag_valid && !proto_err, "R1 reset outputs",
            {ad_out_valid, pl_out_valid, tag_valid, proto_err}, 0);
        rst_n = 1'b1;

        // R10: input offered while idle is not taken
        @(negedge clk);
        in_valid = 1'b1; ad_last = 1'b1; in_be = '1; in_data = rnd128();
        #1;
        chk(!ad_ready && !pl_ready, "R10 idle not ready", {ad_ready, pl_ready}, 0);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0; ad_last = 1'b0;
        chk(!ad_out_valid && !pl_out_valid, "R10 idle input ignored",
            {ad_out_valid, pl_out_valid}, 0);

        msg(1'b0, 1'b0, 2, 3);
        msg(1'b1, 1'b0, 0, 0);
        msg(1'b0, 1'b1, 1, 2);
        msg(1'b1, 1'b1, 0, 0);
        msg(1'b0, 1'b0, 0, 2);

        // R9: malformed byte enable raises and holds the error
        setup(1'b0, 1'b0);
        send(1'b0, rnd128(), 16'h00F0, 1'b1);
        phase(1'b1, 1);
        finish_msg();
        chk(proto_err == 1'b1, "R9 error held to end of message", proto_err, 1);
        msg(1'b1, 1'b0, 1, 1);

        for (int m = 0; m < 30; m++)
            msg($urandom % 2, ($urandom % 3) == 0, $urandom % 4, $urandom % 5);

        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        summary();
        $finish;
    end
endmodule